// File: doc/BRIEF.md
# D-Channel Request/Grant Access Arbiter

This block arbitrates access to a shared D channel on a time-division multiplexed bus. It does this through a request/grant handshake with an external physical-layer device. When the attached HDLC transmitter reports a pending frame, the arbiter raises a request toward the line device. It then waits for a frame sync at which the grant input is high. Only then does it enable the transmitter, so that the opening flag starts in the first D-channel bit of that frame. The grant level captured at each sync is also passed to the D-channel controller as a grant indication.

While transmitting, a drop of the grant input is treated as a collision, and the transmit enable falls in the same cycle. If the transmitter is still inside the first two buffers of the frame, the arbiter issues a one-cycle restart pulse, so the transmitter rewinds to the start of the frame. It then waits for grant at a later sync and resends. A collision after the transmitter has moved past its second buffer cannot be retried: the frame is dropped with a one-cycle error pulse. A saturating counter tracks consecutive collisions on one frame and raises a sticky flag once they exceed a limit chosen at run time.

Top module: `dch_arbiter`

## Requirements
- R1: `req_o` goes high in the cycle after `pending_i` is seen high while idle. It stays high through waiting, sending and backoff. It returns low in the cycle after the frame ends or is abandoned.
- R2: `grant_ind_o` takes the value of `grant_i` on each clock edge where `fsync_i` is high, and holds that value at all other edges. It resets to 0.
- R3: Sending starts only at an edge where `fsync_i` and `grant_i` are both high while the block is requesting. `tx_en_o` is high from the following cycle for as long as `grant_i` stays high.
- R4: While sending, `tx_en_o` is low in any cycle in which `grant_i` is low, and this takes effect with no clock delay.
- R5: A collision is an edge in the sending state with `grant_i` low. If the transmitter has advanced fewer than 2 buffers (each `buf_next_i` pulse while sending advances one buffer), the block enters backoff and `restart_o` is high for exactly the next cycle. The buffer count then restarts at 0.
- R6: In backoff, sending resumes at the first edge with `fsync_i` and `grant_i` both high. `fsync_i` without grant, or grant without `fsync_i`, does not resume it.
- R7: A collision after 2 or more buffer advances returns the block to idle. `late_err_o` is high for exactly the next cycle and `restart_o` stays low.
- R8: Each retried collision increments a saturating count. A collision that finds the count already at or above `max_retry_i` sets `retry_flag_o`. The flag stays set until the next frame begins (idle to requesting), when the flag and the count clear.
- R9: `frame_done_i` while sending returns the block to idle. `frame_done_i` has no effect in any other state. If a collision and `frame_done_i` occur at the same edge, the collision takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus-side clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | Frame sync; grant is sampled at edges where it is high |
| grant_i | input | 1 | Grant from the physical-layer device |
| pending_i | input | 1 | Transmitter has a frame waiting for the D channel |
| buf_next_i | input | 1 | Transmitter moved on to the next buffer of the frame |
| frame_done_i | input | 1 | Closing flag of the frame has been sent |
| max_retry_i | input | CNT_W | Limit on consecutive retried collisions |
| req_o | output | 1 | Request toward the physical-layer device |
| tx_en_o | output | 1 | Transmit enable for the D-channel bits |
| restart_o | output | 1 | Pulse: rewind the frame for retransmission |
| grant_ind_o | output | 1 | Grant level captured at the last sync |
| late_err_o | output | 1 | Pulse: collision too late to retry, frame dropped |
| retry_flag_o | output | 1 | Too many consecutive collisions on the current frame |

## Verification
The main stimulus is a long random run. In it, sync arrives every few cycles and the grant line holds each level for several cycles at a time. Pending requests, buffer advances and frame ends appear randomly. Each output is compared every cycle with a bench reference model. This run separates a block that samples grant at any edge from one that samples only at sync, and early collisions from late ones. Directed cases cover the rest:
- a grant present without sync, which must not start sending;
- a collision coinciding with the frame end, which must retry;
- exactly two buffer advances before a collision, which is the boundary between retry and error;
- repeated collisions against a limit of 1, which must raise the flag on the second collision and clear it at the next frame.

// File: rtl/dch_pkg.sv
package dch_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_REQUEST = 2'd1,
    ST_SEND    = 2'd2,
    ST_BACKOFF = 2'd3
  } dch_state_e;
endpackage

// File: rtl/dch_grant_sampler.sv
module dch_grant_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fsync_i,
  input  logic grant_i,
  output logic grant_ind_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      grant_ind_o <= 1'b0;
    else if (fsync_i) grant_ind_o <= grant_i;
  end

  AST_GIND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(fsync_i) |-> $stable(grant_ind_o)); // R2
endmodule

// File: rtl/dch_buf_tracker.sv
module dch_buf_tracker #(
  parameter int RETRY_BUFS = 2,
  localparam int BW = $clog2(RETRY_BUFS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic adv_i,
  output logic late_o
);
  logic [BW-1:0] cnt_q;

  assign late_o = (cnt_q >= BW'(RETRY_BUFS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (adv_i && !late_o)  cnt_q <= cnt_q + 1'b1;
  end

  AST_BUF_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= BW'(RETRY_BUFS)); // R7
endmodule

// File: rtl/dch_retry_ctr.sv
module dch_retry_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] max_i,
  output logic             flag_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             sat;

  assign sat = &cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      flag_o <= 1'b0;
    end else if (inc_i) begin
      if (!sat)          cnt_q  <= cnt_q + 1'b1;
      if (cnt_q >= max_i) flag_o <= 1'b1;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(flag_o) && !$past(clr_i) |-> flag_o); // R8
endmodule

// File: rtl/dch_arbiter.sv
module dch_arbiter
  import dch_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int RETRY_BUFS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fsync_i,
  input  logic             grant_i,
  input  logic             pending_i,
  input  logic             buf_next_i,
  input  logic             frame_done_i,
  input  logic [CNT_W-1:0] max_retry_i,
  output logic             req_o,
  output logic             tx_en_o,
  output logic             restart_o,
  output logic             grant_ind_o,
  output logic             late_err_o,
  output logic             retry_flag_o
);
  dch_state_e state_q, state_d;
  logic late;
  logic open_win;
  logic collide;
  logic retry_now;
  logic drop_now;
  logic new_frame;
  logic buf_clr;

  assign open_win  = fsync_i && grant_i;
  assign collide   = (state_q == ST_SEND) && !grant_i;
  assign retry_now = collide && !late;
  assign drop_now  = collide && late;
  assign new_frame = (state_q == ST_IDLE) && pending_i;
  assign buf_clr   = (state_q != ST_SEND) || collide;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (pending_i) state_d = ST_REQUEST;
      ST_REQUEST: if (open_win)  state_d = ST_SEND;
      ST_SEND: begin
        if (retry_now)         state_d = ST_BACKOFF;
        else if (drop_now)     state_d = ST_IDLE;
        else if (frame_done_i) state_d = ST_IDLE;
      end
      ST_BACKOFF: if (open_win)  state_d = ST_SEND;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      restart_o  <= 1'b0;
      late_err_o <= 1'b0;
    end else begin
      state_q    <= state_d;
      restart_o  <= retry_now;
      late_err_o <= drop_now;
    end
  end

  assign req_o   = (state_q != ST_IDLE);
  assign tx_en_o = (state_q == ST_SEND) && grant_i;

  dch_grant_sampler u_gsamp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fsync_i     (fsync_i),
    .grant_i     (grant_i),
    .grant_ind_o (grant_ind_o)
  );

  dch_buf_tracker #(.RETRY_BUFS(RETRY_BUFS)) u_bufs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (buf_clr),
    .adv_i  (buf_next_i),
    .late_o (late)
  );

  dch_retry_ctr #(.CNT_W(CNT_W)) u_retry (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (new_frame),
    .inc_i  (retry_now),
    .max_i  (max_retry_i),
    .flag_o (retry_flag_o)
  );

  AST_SEND_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEND) && ($past(state_q) != ST_SEND) |-> $past(fsync_i && grant_i)); // R3
  AST_RESTART_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> !restart_o); // R5
  AST_RESTART_BACKOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> (state_q == ST_BACKOFF)); // R5
  AST_LATE_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_err_o |-> !restart_o && !req_o); // R7
  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_o) |-> $past(frame_done_i || !grant_i)); // R1
  AST_BACKOFF_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_BACKOFF) && !$past(fsync_i) |-> (state_q == ST_BACKOFF)); // R6
endmodule

// File: tb/dch_arbiter_tb.sv
`timescale 1ns/1ps
module dch_arbiter_tb;
  localparam int CNT_W = 4;
  localparam int NB    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fsync = 0, grant = 0, pend = 0, bnext = 0, done = 0;
  logic [CNT_W-1:0] maxr = 4'd1;
  logic req, txen, rst_p, gind, lerr, rflag;

  int checks = 0, fails = 0, cyc = 0;

  // reference model state
  int m_st = 0;  // 0 idle 1 request 2 send 3 backoff
  int m_buf = 0, m_cnt = 0;
  bit m_g = 0, m_rs = 0, m_er = 0, m_fl = 0;

  always #2.5 clk = ~clk;

  dch_arbiter #(.CNT_W(CNT_W), .RETRY_BUFS(NB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fsync_i(fsync), .grant_i(grant),
    .pending_i(pend), .buf_next_i(bnext), .frame_done_i(done),
    .max_retry_i(maxr), .req_o(req), .tx_en_o(txen), .restart_o(rst_p),
    .grant_ind_o(gind), .late_err_o(lerr), .retry_flag_o(rflag)
  );

  task automatic chk(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cyc=%0d actual=%0b expected=%0b", tag, cyc, act, exp);
    end
  endtask

  function automatic bit exp_tx();
    return (m_st == 2) && grant;
  endfunction

  task automatic compare();
    chk(req,   m_st != 0, "R1 req_o");
    chk(gind,  m_g,       "R2 grant_ind_o");
    chk(txen,  exp_tx(),  "R3/R4 tx_en_o");
    chk(rst_p, m_rs,      "R5 restart_o");
    chk(lerr,  m_er,      "R7 late_err_o");
    chk(rflag, m_fl,      "R8 retry_flag_o");
  endtask

  task automatic model_step();
    bit col;
    m_rs = 0; m_er = 0;
    if (fsync) m_g = grant;
    col = (m_st == 2) && !grant;
    case (m_st)
      0: if (pend) begin m_st = 1; m_cnt = 0; m_fl = 0; end
      1: if (fsync && grant) begin m_st = 2; m_buf = 0; end
      2: begin
        if (col && m_buf < NB) begin
          m_st = 3; m_rs = 1; m_buf = 0;
          if (m_cnt >= maxr) m_fl = 1;
          if (m_cnt < 15) m_cnt++;
        end else if (col) begin
          m_st = 0; m_er = 1; m_buf = 0;
        end else if (done) begin
          m_st = 0; m_buf = 0;
        end else if (bnext && m_buf < NB) m_buf++;
      end
      3: if (fsync && grant) begin m_st = 2; m_buf = 0; end
      default: m_st = 0;
    endcase
  endtask

  // drive inputs after negedge, check just before posedge, advance model at posedge
  task automatic step(input bit f, input bit g, input bit p, input bit b, input bit d);
    @(negedge clk);
    fsync = f; grant = g; pend = p; bnext = b; done = d;
    #2;
    compare();
    @(posedge clk);
    model_step();
    cyc++;
  endtask

  initial begin : watchdog
    #(5ns * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    bit g_lvl;
    int g_hold;
    void'($urandom(32'h5eed_1234));
    #1;
    // reset state, R1/R2
    chk(req, 1'b0, "R1 reset req_o");
    chk(gind, 1'b0, "R2 reset grant_ind_o");
    chk(rflag, 1'b0, "R8 reset retry_flag_o");
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R3/R6: grant without sync must not start sending
    step(0,1,1,0,0);
    step(0,1,0,0,0);
    step(0,1,0,0,0);
    step(1,0,0,0,0);               // sync, no grant
    step(1,1,0,0,0);               // start
    step(0,1,0,0,0);
    // R9: done + collision same edge -> retry
    step(0,0,0,0,1);
    step(0,1,0,0,1);               // done ignored in backoff
    step(1,1,0,0,0);               // resume R6
    // R7: two advances then collision
    step(0,1,0,1,0);
    step(0,1,0,1,0);
    step(0,0,0,0,0);
    step(0,0,0,0,0);
    // R8: limit 1 -> flag on second collision, cleared on new frame
    maxr = 4'd1;
    step(0,0,1,0,0);
    step(1,1,0,0,0);
    step(0,0,0,0,0);               // collision 1
    step(1,1,0,0,0);
    step(0,0,0,0,0);               // collision 2 -> flag
    step(1,1,0,0,0);
    step(0,1,0,0,1);               // done
    step(0,0,0,0,0);
    step(0,0,1,0,0);               // new frame clears R8
    step(0,0,0,0,0);
    step(1,1,0,0,0);
    step(0,1,0,0,1);

    // random run
    g_lvl = 1; g_hold = 0;
    for (int i = 0; i < 20000; i++) begin
      bit f, p, b, d;
      if (g_hold == 0) begin
        g_lvl  = ($urandom_range(0, 3) != 0);
        g_hold = $urandom_range(2, 12);
      end
      g_hold--;
      if (i % 1000 == 0) maxr = 4'($urandom_range(0, 4));
      f = (i % 8 == 0) || ($urandom_range(0, 19) == 0);
      p = ($urandom_range(0, 3) == 0);
      b = ($urandom_range(0, 5) == 0);
      d = ($urandom_range(0, 9) == 0);
      step(f, g_lvl, p, b, d);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule